// File: doc/BRIEF.md
# Valid-Flag Dual-Port RAM Mailbox

This block carries messages in one direction between two clock domains that have no fixed relation. The storage is a dual-port RAM with synchronous read and write. Each port is owned by one domain and has its own clock. Every RAM word holds a payload and a flag that marks the word as occupied. No pointer ever crosses the clock boundary. Each side keeps its own pointer, and the only shared state is the occupancy flag in each word.

The producer side writes the payload and a set flag at its pointer, then steps the pointer. In the same cycle, its port reads back the old contents of that word. If the old flag was already set, an unconsumed message has just been overwritten, and the block reports an overrun. A build-time option changes the producer to a stalling variant. In that variant, `wr_ready` is withheld while the target word still holds a message.

The consumer side reads the word at its pointer on every cycle. It trusts a set flag only after a run of fresh samples that all show it set. It then presents the message on a valid/ready output. When the consumer accepts the message, it writes the flag back as clear and steps its pointer.

Top module: `vflag_mailbox`

## Requirements
- R1: While both resets are asserted and in the first cycle after they are released, every flag is clear, `rd_valid` is 0, `wr_overrun` is 0 and `wr_ovr_flag` is 0. In the default (non-stalling) build, `wr_ready` is 1.
- R2: Messages come out of `rd_data` in the order in which they were written, with the payload unchanged and each message exactly once. This holds across many wraps of both pointers, which count modulo DEPTH.
- R3: In the default build, `wr_ready` is always 1. A message is stored on every writer clock edge where `wr_req` is 1, and the writer pointer moves only on those edges.
- R4: A message is presented only after QUAL consecutive fresh reads (default 2) that all see its flag set. As a result, `rd_valid` rises no earlier than the third reader edge after the writer edge that stored the message.
- R5: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` stays stable. The entry is released only on an edge where `rd_valid` and `rd_ready` are both 1. In the reader cycle after that edge, `rd_valid` is 0.
- R6: When a store lands on a word whose flag is still set, `wr_overrun` is 1 for exactly one writer cycle: the cycle after that store. A store onto a clear word never raises it.
- R7: `wr_ovr_flag` becomes 1 in the writer cycle after an overrun pulse. It stays 1 until a cycle with `wr_ovr_clr` at 1, and it reads 0 in the cycle after the clear.
- R8: In the stalling build (STALL_FULL=1), `wr_ready` is 0 while the word at the writer pointer still holds an unconsumed message. The stalled request is accepted after the reader frees that word, and no overrun ever occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer reset, active low, asynchronous |
| wr_data | input | DATA_W | Message payload to store |
| wr_req | input | 1 | Store request |
| wr_ready | output | 1 | A request is accepted when this is 1 |
| wr_overrun | output | 1 | One-cycle pulse: an unconsumed word was overwritten |
| wr_ovr_flag | output | 1 | Sticky overrun status |
| wr_ovr_clr | input | 1 | Clears the sticky overrun status |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer reset, active low, asynchronous |
| rd_data | output | DATA_W | Presented message payload |
| rd_valid | output | 1 | A message is presented |
| rd_ready | input | 1 | The consumer takes the presented message |

## Verification
The hardest state to reach from the ports is a store that lands on a word whose flag is still set, because in ordinary traffic the reader drains each word long before the writer comes back to it. The bench creates this state on purpose. It holds `rd_ready` low so that the reader parks on its first message, fills the whole ring, and then issues one more store. The latency bound of the qualification rule is measured in time, from the accepting writer edge to the first visible `rd_valid`. The stalling build is driven into its blocked state in the same way, and the bench watches for the blocked request to go through once a single message has been consumed.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  typedef enum logic {RS_POLL = 1'b0, RS_HOLD = 1'b1} rd_state_e;

  // Ring pointer step, modulo depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // A word is occupied when the two port-owned toggle bits differ.
  function automatic logic entry_full(input logic wtog, input logic rtog);
    return wtog ^ rtog;
  endfunction
endpackage

// File: rtl/vfm_dpram.sv
module vfm_dpram
  import vfm_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic [AW-1:0]     a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic              a_rflag,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic [AW-1:0]     b_addr,
  input  logic              b_clr,
  output logic              b_rflag,
  output logic [DATA_W-1:0] b_rdata
);
  // The flag of each word is kept as two toggle bits, one owned by each port,
  // so that every storage bit has a single writer. Writing 1 from port A or 0
  // from port B flips that port's bit only when the flag actually changes.
  logic [DATA_W-1:0] pay [DEPTH];
  logic [DEPTH-1:0]  tog_a, tog_b;
  logic              a_old, b_old;

  assign a_old = entry_full(tog_a[a_addr], tog_b[a_addr]);
  assign b_old = entry_full(tog_a[b_addr], tog_b[b_addr]);

  always_ff @(posedge a_clk) begin
    if (a_we) pay[a_addr] <= a_wdata;
  end

  // Port A: read-before-write of the flag, then set it.
  always_ff @(posedge a_clk or negedge a_rst_n) begin
    if (!a_rst_n) begin
      tog_a   <= '0;
      a_rflag <= 1'b0;
    end else begin
      a_rflag <= a_old;
      if (a_we && !a_old) tog_a[a_addr] <= ~tog_a[a_addr];
    end
  end

  // Port B: synchronous read of flag and payload, optional clear of the flag.
  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      tog_b   <= '0;
      b_rflag <= 1'b0;
      b_rdata <= '0;
    end else begin
      b_rflag <= b_old;
      b_rdata <= pay[b_addr];
      if (b_clr && b_old) tog_b[b_addr] <= ~tog_b[b_addr];
    end
  end
endmodule

// File: rtl/vfm_wr_engine.sv
module vfm_wr_engine
  import vfm_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 16,
  parameter bit STALL_FULL = 1'b0,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [DATA_W-1:0] data,
  input  logic              ovr_clr,
  input  logic              ram_rflag,
  output logic              ready,
  output logic              fire,
  output logic              overrun,
  output logic              ovr_flag,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata
);
  logic [AW-1:0] ptr;
  logic          fired_q;

  assign fire      = req && ready;
  assign ram_addr  = ptr;
  assign ram_we    = fire;
  assign ram_wdata = data;
  // The flag read back on the storing edge is the word's previous state.
  assign overrun   = fired_q && ram_rflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      fired_q  <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      fired_q <= fire;
      if (fire) ptr <= AW'(wrap_inc(32'(ptr), DEPTH));
      if (overrun)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end

  if (STALL_FULL) begin : g_stall
    // The read data describes the current pointer only if the pointer did not
    // move on the last edge.
    logic samp_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) samp_ok_q <= 1'b0;
      else        samp_ok_q <= !fire;
    end
    assign ready = samp_ok_q && !ram_rflag;
  end else begin : g_free
    assign ready = 1'b1;
  end
endmodule

// File: rtl/vfm_rd_engine.sv
module vfm_rd_engine
  import vfm_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int QUAL   = 2,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_rflag,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [AW-1:0]     ram_addr,
  output logic              ram_clr,
  output logic              fresh_set
);
  localparam int CW = $clog2(QUAL + 1);

  rd_state_e         state;
  logic [AW-1:0]     ptr;
  logic [CW-1:0]     hits;
  logic              samp_ok_q;
  logic [DATA_W-1:0] data_q;
  logic              adv;

  assign adv       = (state == RS_HOLD) && out_ready;
  assign ram_clr   = adv;
  assign ram_addr  = ptr;
  assign out_valid = (state == RS_HOLD);
  assign out_data  = data_q;
  assign fresh_set = (state == RS_POLL) && samp_ok_q && ram_rflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RS_POLL;
      ptr       <= '0;
      hits      <= '0;
      samp_ok_q <= 1'b0;
      data_q    <= '0;
    end else begin
      samp_ok_q <= !adv;
      case (state)
        RS_POLL: begin
          if (samp_ok_q) begin
            if (ram_rflag) begin
              if (hits == CW'(QUAL - 1)) begin
                data_q <= ram_rdata;
                hits   <= '0;
                state  <= RS_HOLD;
              end else begin
                hits <= hits + 1'b1;
              end
            end else begin
              hits <= '0;
            end
          end
        end
        RS_HOLD: begin
          if (out_ready) begin
            ptr   <= AW'(wrap_inc(32'(ptr), DEPTH));
            state <= RS_POLL;
          end
        end
        default: state <= RS_POLL;
      endcase
    end
  end
endmodule

// File: rtl/vflag_mailbox.sv
module vflag_mailbox
  import vfm_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 16,
  parameter int QUAL       = 2,
  parameter bit STALL_FULL = 1'b0
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_req,
  output logic              wr_ready,
  output logic              wr_overrun,
  output logic              wr_ovr_flag,
  input  logic              wr_ovr_clr,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready
);
  localparam int AW = $clog2(DEPTH);

  // Named internal events, visible to the bound checker.
  logic              wr_fire;
  logic [AW-1:0]     wr_ptr;
  logic              wr_we;
  logic [DATA_W-1:0] wr_wdata;
  logic              wr_old_flag;
  logic [AW-1:0]     rd_ptr;
  logic              rd_clr;
  logic              rd_flag;
  logic [DATA_W-1:0] rd_word;
  logic              rd_fresh_set;

  vfm_dpram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .a_clk(wr_clk), .a_rst_n(wr_rst_n), .a_addr(wr_ptr), .a_we(wr_we),
    .a_wdata(wr_wdata), .a_rflag(wr_old_flag),
    .b_clk(rd_clk), .b_rst_n(rd_rst_n), .b_addr(rd_ptr), .b_clr(rd_clr),
    .b_rflag(rd_flag), .b_rdata(rd_word)
  );

  vfm_wr_engine #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STALL_FULL(STALL_FULL)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_req), .data(wr_data),
    .ovr_clr(wr_ovr_clr), .ram_rflag(wr_old_flag), .ready(wr_ready),
    .fire(wr_fire), .overrun(wr_overrun), .ovr_flag(wr_ovr_flag),
    .ram_addr(wr_ptr), .ram_we(wr_we), .ram_wdata(wr_wdata)
  );

  vfm_rd_engine #(.DEPTH(DEPTH), .DATA_W(DATA_W), .QUAL(QUAL)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .ram_rflag(rd_flag), .ram_rdata(rd_word),
    .out_ready(rd_ready), .out_valid(rd_valid), .out_data(rd_data),
    .ram_addr(rd_ptr), .ram_clr(rd_clr), .fresh_set(rd_fresh_set)
  );
endmodule

// File: rtl/vfm_checker.sv
module vfm_checker #(
  parameter int DEPTH      = 8,
  parameter int DATA_W     = 16,
  parameter bit STALL_FULL = 1'b0,
  localparam int AW        = $clog2(DEPTH)
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_fire,
  input logic [AW-1:0]     wr_ptr,
  input logic              wr_overrun,
  input logic              wr_ovr_flag,
  input logic              wr_ovr_clr,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [AW-1:0]     rd_ptr,
  input logic              rd_fresh_set
);
  // R3: the writer pointer moves only on an accepted store.
  a_r3_ptr_hold: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_fire |=> $stable(wr_ptr));

  // R5: a presented message stays put until it is taken.
  a_r5_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R5: the reader pointer moves only on a completed handshake.
  a_r5_rd_ptr_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !(rd_valid && rd_ready) |=> $stable(rd_ptr));

  // R4: a presentation follows two back-to-back fresh set samples.
  a_r4_qualified: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(rd_valid) |-> $past(rd_fresh_set) && $past(rd_fresh_set, 2));

  // R6: an overrun pulse is always the cycle after a store.
  a_r6_after_store: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_overrun |-> $past(wr_fire));

  // R7: the sticky status follows the pulse and holds until cleared.
  a_r7_sticky_set: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_overrun |=> wr_ovr_flag);
  a_r7_sticky_keep: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_ovr_flag && !wr_ovr_clr |=> wr_ovr_flag);

  if (STALL_FULL) begin : g_stall_chk
    // R8: the stalling build never overwrites an occupied word.
    a_r8_no_overrun: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_fire |=> !wr_overrun);
  end
endmodule

bind vflag_mailbox vfm_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STALL_FULL(STALL_FULL)) u_chk (.*);

// File: tb/tb_vflag_mailbox.sv
module tb_vflag_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 3;
  localparam int DEPTH      = 8;
  localparam int DATA_W     = 16;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic [DATA_W-1:0] wr_data = '0, rd_data, s_wr_data = '0, s_rd_data;
  logic wr_req = 1'b0, wr_ready, wr_overrun, wr_ovr_flag, wr_ovr_clr = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic s_wr_req = 1'b0, s_wr_ready, s_wr_overrun, s_wr_ovr_flag;
  logic s_rd_valid, s_rd_ready = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0, ready_low_seen = 1'b0, s_ovr_seen = 1'b0;
  time t_acc, t_val;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #(RD_PERIOD/2.0) rd_clk = ~rd_clk;
  end

  vflag_mailbox #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_req(wr_req),
    .wr_ready(wr_ready), .wr_overrun(wr_overrun), .wr_ovr_flag(wr_ovr_flag),
    .wr_ovr_clr(wr_ovr_clr), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready));

  vflag_mailbox #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STALL_FULL(1'b1)) dut_s (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(s_wr_data), .wr_req(s_wr_req),
    .wr_ready(s_wr_ready), .wr_overrun(s_wr_overrun), .wr_ovr_flag(s_wr_ovr_flag),
    .wr_ovr_clr(1'b0), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .rd_data(s_rd_data), .rd_valid(s_rd_valid), .rd_ready(s_rd_ready));

  // R3 and R8 monitors
  always @(negedge wr_clk) begin
    if (wr_rst_n && !wr_ready) ready_low_seen = 1'b1;
    if (wr_rst_n && s_wr_overrun) s_ovr_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    wr_req = 1'b0; s_wr_req = 1'b0; rd_ready = 1'b0; s_rd_ready = 1'b0; wr_ovr_clr = 1'b0;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk);
    chk(!rd_valid && !wr_overrun && !wr_ovr_flag, "R1", "outputs in reset", rd_valid, 0);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    @(negedge wr_clk);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    chk(!wr_overrun && !wr_ovr_flag, "R1", "overrun after reset", wr_ovr_flag, 0);
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
  endtask

  task automatic t_write(input int d, output bit ovr);
    @(negedge wr_clk);
    wr_data = DATA_W'(d); wr_req = 1'b1;
    while (!wr_ready) @(negedge wr_clk);
    @(posedge wr_clk);
    t_acc = $time;
    @(negedge wr_clk);
    wr_req = 1'b0;
    ovr = wr_overrun;
  endtask

  task automatic s_write(input int d, output bit ovr);
    @(negedge wr_clk);
    s_wr_data = DATA_W'(d); s_wr_req = 1'b1;
    while (!s_wr_ready) @(negedge wr_clk);
    @(posedge wr_clk);
    @(negedge wr_clk);
    s_wr_req = 1'b0;
    ovr = s_wr_overrun;
  endtask

  // Waits for a message, holds ready low for 'hold' cycles, then takes it.
  task automatic rd_take(input int exp, input int hold, input string req);
    int n = 0;
    bit stable = 1'b1;
    @(negedge rd_clk);
    while (!rd_valid && n < 400) begin @(negedge rd_clk); n++; end
    t_val = $time;
    chk(rd_valid == 1'b1, req, "message presented", rd_valid, 1);
    chk(rd_data == DATA_W'(exp), req, "message payload", rd_data, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge rd_clk);
      if (!rd_valid || rd_data != DATA_W'(exp)) stable = 1'b0;
    end
    if (hold > 0) chk(stable, "R5", "held message stable", rd_data, exp);
    rd_ready = 1'b1;
    @(negedge rd_clk);
    rd_ready = 1'b0;
    chk(rd_valid == 1'b0, "R5", "valid drops after take", rd_valid, 0);
  endtask

  task automatic s_take(input int exp);
    int n = 0;
    @(negedge rd_clk);
    while (!s_rd_valid && n < 400) begin @(negedge rd_clk); n++; end
    chk(s_rd_valid && s_rd_data == DATA_W'(exp), "R8", "stall build payload", s_rd_data, exp);
    s_rd_ready = 1'b1;
    @(negedge rd_clk);
    s_rd_ready = 1'b0;
  endtask

  // R4: latency of the two-sample qualification
  task automatic t_latency();
    bit ovr;
    t_write(16'h0A5A, ovr);
    rd_take(16'h0A5A, 0, "R4");
    chk((t_val - t_acc) >= 2 * RD_PERIOD, "R4", "qualify latency ns",
        int'(t_val - t_acc), 2 * RD_PERIOD);
  endtask

  // R2: ordered stream across several wraps with back-pressure
  task automatic t_stream();
    int wn = 0, rn = 0;
    bit any_ovr = 1'b0;
    fork
      for (int i = 0; i < 3 * DEPTH; i++) begin
        bit ovr;
        while (wn - rn >= DEPTH) @(negedge wr_clk);
        t_write(16'h1000 + i, ovr);
        if (ovr) any_ovr = 1'b1;
        wn++;
      end
      for (int i = 0; i < 3 * DEPTH; i++) begin
        rd_take(16'h1000 + i, i % 3, "R2");
        rn++;
      end
    join
    chk(!any_ovr, "R6", "no overrun without wrap", any_ovr, 0);
    chk(!ready_low_seen, "R3", "wr_ready always high", ready_low_seen, 0);
  endtask

  // R5: long hold keeps the message and blocks the next one
  task automatic t_hold();
    bit ovr;
    t_write(16'h2001, ovr);
    t_write(16'h2002, ovr);
    rd_take(16'h2001, 20, "R5");
    rd_take(16'h2002, 0, "R5");
  endtask

  // R6, R7: wrap onto an unconsumed word, then clear the sticky status
  task automatic t_overrun();
    bit ovr, any_ovr = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      t_write(16'h3000 + i, ovr);
      if (ovr) any_ovr = 1'b1;
    end
    chk(!any_ovr, "R6", "no overrun while filling", any_ovr, 0);
    repeat (6) @(negedge rd_clk);
    chk(rd_valid == 1'b1, "R5", "first message parked", rd_valid, 1);
    t_write(16'h3FFF, ovr);
    chk(ovr == 1'b1, "R6", "overrun pulse after wrap store", ovr, 1);
    @(negedge wr_clk);
    chk(wr_overrun == 1'b0, "R6", "pulse lasts one cycle", wr_overrun, 0);
    chk(wr_ovr_flag == 1'b1, "R7", "sticky set after pulse", wr_ovr_flag, 1);
    repeat (5) @(negedge wr_clk);
    chk(wr_ovr_flag == 1'b1, "R7", "sticky holds", wr_ovr_flag, 1);
    wr_ovr_clr = 1'b1;
    @(negedge wr_clk);
    wr_ovr_clr = 1'b0;
    chk(wr_ovr_flag == 1'b0, "R7", "sticky cleared", wr_ovr_flag, 0);
    t_reset();
  endtask

  // R8: stalling build blocks on a full ring and resumes after one take
  task automatic t_stall();
    bit ovr, blocked_ovr;
    for (int i = 0; i < DEPTH; i++) s_write(16'h4000 + i, ovr);
    fork
      s_write(16'h4FFF, blocked_ovr);
      begin
        repeat (12) @(negedge wr_clk);
        chk(!s_wr_ready && s_wr_req, "R8", "ready low on full ring", s_wr_ready, 0);
        s_take(16'h4000);
      end
    join
    chk(!blocked_ovr, "R8", "blocked store no overrun", blocked_ovr, 0);
    for (int i = 1; i < DEPTH; i++) s_take(16'h4000 + i);
    s_take(16'h4FFF);
    chk(!s_ovr_seen, "R8", "never overruns", s_ovr_seen, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_stream();
    t_hold();
    t_overrun();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule